// File: doc/BRIEF.md
# Real-Time-Clock Interrupt Emulation Engine

This block recreates the three interrupt sources of a classic real-time clock from a single programmable interval timer: an update interrupt that fires once the seconds value moves on, a time-of-day alarm, and a periodic interrupt at a power-of-two rate from 2 Hz to 8192 Hz. The timer runs at a 64 Hz polling rate (`BASE_CYCLES` clock cycles per poll). Update and alarm conditions are only evaluated on these polls. Periodic rates of 64 Hz or less are produced by dividing the poll. Faster rates shorten the poll interval instead.

The current hours, minutes and seconds come from an external clock-keeping block. The alarm time and the three source enables come from configuration. While `busy_i` is high, expiring polls are not serviced. Each one is counted as lost, and the count is added to the periodic divider at the next serviced poll. Raised flags collect in a status word until software reads it. Each serviced poll that raises a flag emits one interrupt pulse.

Top module: `rtc_emu`

## Requirements
- R1: After reset, `irq_o` is 0 and `status_o` is 0. The last recorded seconds value is 0, and the periodic and lost counters are 0.
- R2: While all three enables are low, the timer is stopped and no poll occurs. In the cycle any enable first goes high, the timer restarts. The first poll then falls `interval` cycles later.
- R3: Polls recur every `BASE_CYCLES` cycles, except in the case covered by R7.
- R4: On a serviced poll with the update enable high, if `sec_i` differs from the last recorded seconds value, the engine sets flag bit 0 and records `sec_i`.
- R5: On a serviced poll with the alarm enable high, if hours, minutes and seconds all equal the alarm inputs, the engine sets flag bit 2.
- R6: With the periodic enable high and a rate exponent s ≤ 6 (rate 2^s Hz), each serviced poll adds 1 to the periodic count. When the count reaches the limit 2^(6−s), the engine sets flag bit 1 and clears the count.
- R7: With the periodic enable high and s > 6, the poll interval is `BASE_CYCLES >> (s−6)`, the limit is 1, and every serviced poll sets flag bit 1.
- R8: A poll that expires while `busy_i` is high is not serviced. It raises no flag, and it increments a saturating lost counter. The next serviced poll adds 1 plus the lost count to the periodic count and clears the lost counter.
- R9: `status_o` has the flags in bits 2:0 and a pending bit in bit 7. Bits 15:8 hold 1 when any flag is set and 0 otherwise. All other bits are 0. Flags stay set until `rd_i` is sampled high, which clears them. A flag raised in that same cycle stays set.
- R10: `irq_o` is a one-cycle pulse. It is high in the cycle after a serviced poll that raises at least one flag, and low at all other times.
- R11: A rate exponent below 1 is treated as 1, and one above 13 is treated as 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_upd_i | input | 1 | Update source enable |
| en_alm_i | input | 1 | Alarm source enable |
| en_per_i | input | 1 | Periodic source enable |
| freq_sel_i | input | 4 | Periodic rate exponent s (rate 2^s Hz) |
| busy_i | input | 1 | High while polls cannot be serviced |
| hour_i | input | 5 | Current hours |
| min_i | input | 6 | Current minutes |
| sec_i | input | 6 | Current seconds |
| alm_hour_i | input | 5 | Alarm hours |
| alm_min_i | input | 6 | Alarm minutes |
| alm_sec_i | input | 6 | Alarm seconds |
| rd_i | input | 1 | Status read strobe, clears flags |
| irq_o | output | 1 | Interrupt pulse |
| status_o | output | 16 | Status word |

## Verification
The assertions check four local rules on every cycle:
- no poll occurs in the cycle the timer restarts;
- two polls never occur in consecutive cycles;
- an interrupt never follows a cycle without a serviced poll, and always comes with the pending bit;
- a read with no new event leaves the flags clear.

Only the bench's scenarios can show the following:
- poll timing over whole intervals;
- the divider limits at low and high rates;
- exponent clamping;
- the catch-up of polls lost while busy;
- the sticky read-clear behaviour.

The bench covers these with a cycle-accurate behavioural model compared on every clock.

// File: rtl/rtc_emu_pkg.sv
package rtc_emu_pkg;
  localparam int SEL_W    = 4;
  localparam int BASE_SEL = 6;   // log2 of the 64 Hz polling rate
  localparam int MIN_SEL  = 1;
  localparam int MAX_SEL  = 13;

  typedef struct packed {
    logic alm;   // bit 2
    logic per;   // bit 1
    logic upd;   // bit 0
  } rtc_flags_t;

  function automatic logic [SEL_W-1:0] clamp_sel(input logic [SEL_W-1:0] s);
    if (s < SEL_W'(MIN_SEL)) return SEL_W'(MIN_SEL);
    if (s > SEL_W'(MAX_SEL)) return SEL_W'(MAX_SEL);
    return s;
  endfunction
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen
  import rtc_emu_pkg::*;
#(
  parameter int BASE_CYCLES = 256,
  parameter int LOST_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              per_en_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              busy_i,
  output logic              svc_o,
  output logic [LOST_W-1:0] lost_o
);
  localparam int CNT_W     = $clog2(BASE_CYCLES + 1);
  localparam int MIN_DELTA = BASE_CYCLES >> (MAX_SEL - BASE_SEL);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q, delta;
  logic [LOST_W-1:0] lost_q;
  logic             tick;

  always_comb begin
    if (per_en_i && sel_i > SEL_W'(BASE_SEL))
      delta = CNT_W'(BASE_CYCLES) >> (sel_i - SEL_W'(BASE_SEL));
    else
      delta = CNT_W'(BASE_CYCLES);
  end

  assign tick   = run_i && run_q && (cnt_q == '0);
  assign svc_o  = tick && !busy_i;
  assign lost_o = lost_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      lost_q <= '0;
    end else begin
      run_q <= run_i;
      if (!run_i)                      cnt_q <= '0;
      else if (!run_q || cnt_q == '0)  cnt_q <= delta - 1'b1;
      else                             cnt_q <= cnt_q - 1'b1;
      if (tick && busy_i) begin
        if (lost_q != '1) lost_q <= lost_q + 1'b1;
      end else if (svc_o) begin
        lost_q <= '0;
      end
    end
  end

  // R2: restart cycle never yields a poll
  a_r2_no_poll_on_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> !tick);
  // R3: polls are spaced at least two cycles apart for the default sizing
  a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && MIN_DELTA > 1) |=> !tick);
endmodule

// File: rtl/rtc_event_eval.sv
module rtc_event_eval
  import rtc_emu_pkg::*;
#(
  parameter int LOST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              svc_i,
  input  logic [LOST_W-1:0] lost_i,
  input  logic              en_upd_i,
  input  logic              en_alm_i,
  input  logic              en_per_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              time_match_i,
  input  logic [5:0]        sec_i,
  input  logic              rd_i,
  output rtc_flags_t        flags_o,
  output logic              irq_o
);
  localparam int PC_W = LOST_W + 2;

  rtc_flags_t      flags_q, new_f;
  logic [5:0]      prev_sec_q;
  logic [PC_W-1:0] per_cnt_q, per_sum, limit;
  logic            irq_q;

  always_comb begin
    if (sel_i <= SEL_W'(BASE_SEL))
      limit = PC_W'(1) << (SEL_W'(BASE_SEL) - sel_i);
    else
      limit = PC_W'(1);
    per_sum   = per_cnt_q + PC_W'(1) + PC_W'(lost_i);
    new_f.upd = svc_i && en_upd_i && (sec_i != prev_sec_q);
    new_f.alm = svc_i && en_alm_i && time_match_i;
    new_f.per = svc_i && en_per_i && (per_sum >= limit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q    <= '0;
      prev_sec_q <= '0;
      per_cnt_q  <= '0;
      irq_q      <= 1'b0;
    end else begin
      flags_q <= (rd_i ? rtc_flags_t'('0) : flags_q) | new_f;
      irq_q   <= |new_f;
      if (new_f.upd) prev_sec_q <= sec_i;
      if (svc_i && en_per_i) per_cnt_q <= new_f.per ? '0 : per_sum;
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = irq_q;

  // R10: no interrupt without a serviced poll one cycle earlier
  a_r10_irq_needs_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !svc_i |=> !irq_o);
  // R9: a read with no concurrent poll clears every flag
  a_r9_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !svc_i) |=> (flags_o == '0));
endmodule

// File: rtl/rtc_emu.sv
module rtc_emu
  import rtc_emu_pkg::*;
#(
  parameter int BASE_CYCLES = 256,
  parameter int LOST_W      = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_upd_i,
  input  logic        en_alm_i,
  input  logic        en_per_i,
  input  logic [3:0]  freq_sel_i,
  input  logic        busy_i,
  input  logic [4:0]  hour_i,
  input  logic [5:0]  min_i,
  input  logic [5:0]  sec_i,
  input  logic [4:0]  alm_hour_i,
  input  logic [5:0]  alm_min_i,
  input  logic [5:0]  alm_sec_i,
  input  logic        rd_i,
  output logic        irq_o,
  output logic [15:0] status_o
);
  logic [SEL_W-1:0]  sel_c;
  logic              run, svc, match, pend;
  logic [LOST_W-1:0] lost;
  rtc_flags_t        flags;

  assign sel_c = clamp_sel(freq_sel_i);
  assign run   = en_upd_i || en_alm_i || en_per_i;
  assign match = (hour_i == alm_hour_i) && (min_i == alm_min_i) && (sec_i == alm_sec_i);

  rtc_tick_gen #(.BASE_CYCLES(BASE_CYCLES), .LOST_W(LOST_W)) u_tick (
    .clk_i, .rst_ni,
    .run_i    (run),
    .per_en_i (en_per_i),
    .sel_i    (sel_c),
    .busy_i,
    .svc_o    (svc),
    .lost_o   (lost)
  );

  rtc_event_eval #(.LOST_W(LOST_W)) u_eval (
    .clk_i, .rst_ni,
    .svc_i        (svc),
    .lost_i       (lost),
    .en_upd_i, .en_alm_i, .en_per_i,
    .sel_i        (sel_c),
    .time_match_i (match),
    .sec_i,
    .rd_i,
    .flags_o      (flags),
    .irq_o
  );

  assign pend     = |flags;
  assign status_o = {7'd0, pend, pend, 4'd0, flags};

  // R10: an interrupt pulse always comes with the pending bit
  a_r10_irq_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status_o[7]);
endmodule

// File: tb/rtc_emu_tb.sv
module rtc_emu_tb;
  localparam int BASE = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_upd = 0, en_alm = 0, en_per = 0, busy = 0, rd = 0;
  logic [3:0] fsel = 4'd6;
  logic [4:0] hour = 0, ahour = 0;
  logic [5:0] mins = 0, sec = 0, amin = 0, asec = 0;
  logic irq;
  logic [15:0] status;

  always #4 clk = ~clk;

  rtc_emu #(.BASE_CYCLES(BASE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_upd_i(en_upd), .en_alm_i(en_alm), .en_per_i(en_per),
    .freq_sel_i(fsel), .busy_i(busy), .hour_i(hour), .min_i(mins), .sec_i(sec),
    .alm_hour_i(ahour), .alm_min_i(amin), .alm_sec_i(asec), .rd_i(rd),
    .irq_o(irq), .status_o(status));

  int checks = 0, fails = 0, irqs = 0;
  string phase = "R1";

  // behavioural reference state
  bit m_run = 0, m_irq = 0;
  int m_cnt = 0, m_lost = 0, m_pc = 0, m_prev = 0, m_flags = 0;

  function automatic int csel(int s);
    return (s < 1) ? 1 : (s > 13) ? 13 : s;
  endfunction

  task automatic model_edge();
    int s, d, lim, f;
    bit tick;
    s = csel(int'(fsel));
    d = (en_per && s > 6) ? (BASE >> (s - 6)) : BASE;
    lim = (s <= 6) ? (1 << (6 - s)) : 1;
    tick = 0;
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_lost = 0; m_pc = 0; m_prev = 0; m_flags = 0; m_irq = 0;
      return;
    end
    if (!(en_upd || en_alm || en_per)) begin m_run = 0; m_cnt = 0; end
    else if (!m_run) begin m_run = 1; m_cnt = d - 1; end
    else if (m_cnt == 0) begin tick = 1; m_cnt = d - 1; end
    else m_cnt--;
    f = 0;
    if (tick && busy) begin
      if (m_lost < 255) m_lost++;
    end else if (tick) begin
      if (en_upd && int'(sec) != m_prev) begin f |= 1; m_prev = int'(sec); end
      if (en_alm && hour == ahour && mins == amin && sec == asec) f |= 4;
      if (en_per) begin
        m_pc += 1 + m_lost;
        if (m_pc >= lim) begin f |= 2; m_pc = 0; end
      end
      m_lost = 0;
    end
    m_flags = (rd ? 0 : m_flags) | f;
    m_irq = (f != 0);
  endtask

  task automatic step();
    int exp_st;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    exp_st = (m_flags != 0) ? (16'h0180 | m_flags) : 0;
    checks++;
    if (irq) irqs++;
    if (irq !== m_irq || status !== 16'(exp_st)) begin
      fails++;
      $display("FAIL %s: irq=%0b status=%h expected irq=%0b status=%h",
               phase, irq, status, m_irq, 16'(exp_st));
    end
  endtask

  task automatic run(int n, int rd_every);
    for (int i = 1; i <= n; i++) begin
      rd = (rd_every > 0) && (i % rd_every == 0);
      step();
    end
    rd = 0;
  endtask

  task automatic expect_irqs(int from, int exp, string tag);
    checks++;
    if (irqs - from != exp) begin
      fails++;
      $display("FAIL %s: irq pulses=%0d expected %0d", tag, irqs - from, exp);
    end
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    int base;
    // R1: reset state
    run(4, 0);
    rst_n = 1;
    run(4, 0);
    // R3/R4: update polling at the base interval
    phase = "R4"; en_upd = 1; sec = 6'd5;
    base = irqs;
    run(3 * BASE + 10, 0);
    expect_irqs(base, 1, "R3");
    sec = 6'd6;
    run(BASE, 0);
    phase = "R9"; run(BASE, 100);
    // R5: alarm match
    phase = "R5"; en_alm = 1; ahour = 5'd3; amin = 6'd7; asec = 6'd6;
    hour = 5'd3; mins = 6'd7;
    run(2 * BASE, 50);
    hour = 5'd4; run(BASE, 0);
    // R2: stop then restart
    phase = "R2"; en_upd = 0; en_alm = 0;
    base = irqs;
    run(3 * BASE, 7);
    expect_irqs(base, 0, "R2");
    sec = 6'd9; en_upd = 1;
    run(2 * BASE, 0);
    // R6: divided periodic rates
    phase = "R6"; en_upd = 0; en_per = 1; fsel = 4'd5;
    run(6 * BASE, 300);
    fsel = 4'd1;
    base = irqs;
    run(33 * BASE, 1000);
    // R7: shortened intervals
    phase = "R7"; fsel = 4'd10;
    run(200, 40);
    fsel = 4'd13;
    run(60, 9);
    // R11: exponent clamping
    phase = "R11"; fsel = 4'd15;
    run(60, 0);
    fsel = 4'd0;
    run(40 * BASE, 500);
    // R8: lost polls while busy
    phase = "R8"; fsel = 4'd4;
    run(BASE, 0);
    busy = 1;
    run(3 * BASE + 20, 0);
    busy = 0;
    run(3 * BASE, 200);
    busy = 1; fsel = 4'd12;
    run(100, 0);
    busy = 0;
    run(100, 30);
    // R10: pulses continue to match the model after reset
    phase = "R10"; rst_n = 0;
    run(3, 0);
    rst_n = 1;
    run(2 * BASE, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule